// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 36-bit virtual page number into a 40-bit physical page number. It walks a radix tree of four levels held in memory. A client hands it a request together with the physical base of the top-level table. The walker then reads one 64-bit entry per level through a simple memory read port. The entry address at each level comes from the current table base and a 9-bit slice of the virtual page number. Each entry read either points to the next table or, at the last level, gives the translated page.

Each entry carries a present flag in its lowest bit. A cleared flag stops the walk at once and reports a fault with the level where the walk stopped. A successful walk reports the page number taken from the fourth-level entry. The client forms the full physical address by joining that page number to the untouched 12-bit page offset. Only one walk runs at a time. The walker waits as long as memory needs, both for request acceptance and for each response.

Top module: `page_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready_o` is 1, and `mem_req_valid_o` and `done_valid_o` are 0.
- R2: A request is taken only when `req_ready_o` is 1, and `req_ready_o` stays 0 from acceptance until the walk completes. A request presented during a walk has no effect on its addresses or result.
- R3: The first read goes to `{root, 12'h000} + vpn[35:27]*8`, using the root base captured when the request was accepted.
- R4: Reads two, three and four go to `{next_base, 12'h000} + idx*8`. Here `next_base` is bits [51:12] of the previous entry, and `idx` is `vpn[26:18]`, `vpn[17:9]` and `vpn[8:0]` in turn.
- R5: While `mem_req_valid_o` is 1 and `mem_req_ready_i` is 0, the request stays valid and its address does not change.
- R6: After a read is accepted, no new read is issued until its response (`mem_rsp_valid_i`) arrives, however many cycles that takes.
- R7: An entry with bit 0 clear ends the walk with `done_fault_o`=1 and `done_level_o` giving the level (0 = first table … 3 = fourth table). `done_ppn_o` is 0 and no further read is issued.
- R8: When all four entries have bit 0 set, the walk ends with `done_fault_o`=0, `done_level_o`=3 and `done_ppn_o` equal to bits [51:12] of the fourth entry. The bits of an entry outside [51:12] and bit 0 are ignored.
- R9: `done_valid_o` is a one-cycle pulse in the cycle after the final response, and the walker is idle (`req_ready_o`=1) in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Walker idle, request accepted |
| req_vpn_i | input | 36 | Virtual page number to translate |
| root_base_i | input | 40 | Physical base page of the first-level table |
| mem_req_valid_o | output | 1 | Entry read request valid |
| mem_req_ready_i | input | 1 | Memory accepts the read |
| mem_req_addr_o | output | 52 | Byte address of the entry |
| mem_rsp_valid_i | input | 1 | Entry data valid |
| mem_rsp_data_i | input | 64 | Entry data |
| done_valid_o | output | 1 | Walk result valid (one cycle) |
| done_fault_o | output | 1 | Walk stopped on a non-present entry |
| done_level_o | output | 2 | Level of the last entry read |
| done_ppn_o | output | 40 | Translated physical page number |

## Verification
The assertions take for granted that memory never returns a response unless a read has been accepted and is still waiting. They also assume at most one response per accepted read. The bench memory model keeps to this: it raises `mem_rsp_valid_i` for exactly one cycle, and only after it has seen the handshake for that read. The sweep covers stopping levels 0 to 3, full walks, index fields that are all zeros or all ones, and several acceptance and response delays.

// File: rtl/page_walker_pkg.sv
package page_walker_pkg;
  localparam int unsigned OFS_W = 12;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_DONE} walk_st_e;
endpackage

// File: rtl/page_walker_idx.sv
module page_walker_idx #(
  parameter int unsigned LEVELS = 4,
  parameter int unsigned IDX_W  = 9,
  localparam int unsigned VPN_W = LEVELS * IDX_W,
  localparam int unsigned LVL_W = $clog2(LEVELS)
) (
  input  logic [VPN_W-1:0] vpn_i,
  input  logic [LVL_W-1:0] level_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] field [LEVELS];

  // level 0 takes the most significant slice
  for (genvar l = 0; l < LEVELS; l++) begin : g_field
    assign field[l] = vpn_i[(LEVELS-1-l)*IDX_W +: IDX_W];
  end

  assign idx_o = field[level_i];
endmodule

// File: rtl/page_walker_addr.sv
module page_walker_addr #(
  parameter int unsigned PPN_W = 40,
  parameter int unsigned IDX_W = 9,
  parameter int unsigned PTE_W = 64,
  localparam int unsigned ADDR_W = PPN_W + page_walker_pkg::OFS_W,
  localparam int unsigned ENT_LG = $clog2(PTE_W / 8)
) (
  input  logic [PPN_W-1:0]  base_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [ADDR_W-1:0] addr_o
);
  assign addr_o = {base_i, {page_walker_pkg::OFS_W{1'b0}}} + (ADDR_W'(idx_i) << ENT_LG);
endmodule

// File: rtl/page_walker_fsm.sv
module page_walker_fsm
  import page_walker_pkg::*;
#(
  parameter int unsigned LEVELS = 4,
  parameter int unsigned IDX_W  = 9,
  parameter int unsigned PPN_W  = 40,
  parameter int unsigned PTE_W  = 64,
  localparam int unsigned VPN_W = LEVELS * IDX_W,
  localparam int unsigned LVL_W = $clog2(LEVELS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [VPN_W-1:0] req_vpn_i,
  input  logic [PPN_W-1:0] root_base_i,
  input  logic             mem_req_ready_i,
  input  logic             mem_rsp_valid_i,
  input  logic [PTE_W-1:0] mem_rsp_data_i,
  output walk_st_e         state_o,
  output logic [VPN_W-1:0] vpn_o,
  output logic [PPN_W-1:0] base_o,
  output logic [LVL_W-1:0] level_o,
  output logic             fault_o,
  output logic [PPN_W-1:0] ppn_o
);
  localparam logic [LVL_W-1:0] LAST = LVL_W'(LEVELS - 1);

  walk_st_e         st_q;
  logic [VPN_W-1:0] vpn_q;
  logic [PPN_W-1:0] base_q, ppn_q;
  logic [LVL_W-1:0] lvl_q;
  logic             fault_q;

  logic             present;
  logic [PPN_W-1:0] pte_ppn;
  logic             unused_pte_bits;

  assign present         = mem_rsp_data_i[0];
  assign pte_ppn         = mem_rsp_data_i[OFS_W +: PPN_W];
  assign unused_pte_bits = ^{mem_rsp_data_i[PTE_W-1:OFS_W+PPN_W], mem_rsp_data_i[OFS_W-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      vpn_q   <= '0;
      base_q  <= '0;
      lvl_q   <= '0;
      fault_q <= 1'b0;
      ppn_q   <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          vpn_q  <= req_vpn_i;
          base_q <= root_base_i;
          lvl_q  <= '0;
          st_q   <= ST_REQ;
        end
        ST_REQ: if (mem_req_ready_i) st_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid_i) begin
          if (!present) begin
            fault_q <= 1'b1;
            ppn_q   <= '0;
            st_q    <= ST_DONE;
          end else if (lvl_q == LAST) begin
            fault_q <= 1'b0;
            ppn_q   <= pte_ppn;
            st_q    <= ST_DONE;
          end else begin
            base_q <= pte_ppn;
            lvl_q  <= lvl_q + 1'b1;
            st_q   <= ST_REQ;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = st_q;
  assign vpn_o   = vpn_q;
  assign base_o  = base_q;
  assign level_o = lvl_q;
  assign fault_o = fault_q;
  assign ppn_o   = ppn_q;
endmodule

// File: rtl/page_walker.sv
module page_walker
  import page_walker_pkg::*;
#(
  parameter int unsigned LEVELS = 4,
  parameter int unsigned IDX_W  = 9,
  parameter int unsigned PPN_W  = 40,
  parameter int unsigned PTE_W  = 64,
  localparam int unsigned VPN_W  = LEVELS * IDX_W,
  localparam int unsigned LVL_W  = $clog2(LEVELS),
  localparam int unsigned ADDR_W = PPN_W + OFS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [VPN_W-1:0]  req_vpn_i,
  input  logic [PPN_W-1:0]  root_base_i,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [ADDR_W-1:0] mem_req_addr_o,
  input  logic              mem_rsp_valid_i,
  input  logic [PTE_W-1:0]  mem_rsp_data_i,
  output logic              done_valid_o,
  output logic              done_fault_o,
  output logic [LVL_W-1:0]  done_level_o,
  output logic [PPN_W-1:0]  done_ppn_o
);
  walk_st_e         st;
  logic [VPN_W-1:0] vpn;
  logic [PPN_W-1:0] base;
  logic [LVL_W-1:0] lvl;
  logic [IDX_W-1:0] idx;

  page_walker_fsm #(
    .LEVELS(LEVELS), .IDX_W(IDX_W), .PPN_W(PPN_W), .PTE_W(PTE_W)
  ) u_fsm (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .req_valid_i     (req_valid_i),
    .req_vpn_i       (req_vpn_i),
    .root_base_i     (root_base_i),
    .mem_req_ready_i (mem_req_ready_i),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .mem_rsp_data_i  (mem_rsp_data_i),
    .state_o         (st),
    .vpn_o           (vpn),
    .base_o          (base),
    .level_o         (lvl),
    .fault_o         (done_fault_o),
    .ppn_o           (done_ppn_o)
  );

  page_walker_idx #(.LEVELS(LEVELS), .IDX_W(IDX_W)) u_idx (
    .vpn_i   (vpn),
    .level_i (lvl),
    .idx_o   (idx)
  );

  page_walker_addr #(.PPN_W(PPN_W), .IDX_W(IDX_W), .PTE_W(PTE_W)) u_addr (
    .base_i (base),
    .idx_i  (idx),
    .addr_o (mem_req_addr_o)
  );

  assign req_ready_o     = (st == ST_IDLE);
  assign mem_req_valid_o = (st == ST_REQ);
  assign done_valid_o    = (st == ST_DONE);
  assign done_level_o    = lvl;
endmodule

// File: rtl/page_walker_chk.sv
module page_walker_chk #(
  parameter int unsigned ADDR_W = 52,
  parameter int unsigned LVL_W  = 2,
  parameter int unsigned LEVELS = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              mem_req_valid_o,
  input logic              mem_req_ready_i,
  input logic [ADDR_W-1:0] mem_req_addr_o,
  input logic              mem_rsp_valid_i,
  input logic              done_valid_o,
  input logic              done_fault_o,
  input logic [LVL_W-1:0]  done_level_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             pend_q <= 1'b0;
    else if (mem_req_valid_o && mem_req_ready_i) pend_q <= 1'b1;
    else if (mem_rsp_valid_i)                pend_q <= 1'b0;
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_idle: assert (req_ready_o && !mem_req_valid_o && !done_valid_o);
    end
  end

  a_r2_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !req_ready_o);

  a_r5_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o));

  a_r6_one_outstanding: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> !mem_req_valid_o);

  a_r6_rsp_expected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rsp_valid_i |-> pend_q);

  a_r7_no_read_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_valid_o |-> !mem_req_valid_o);

  a_r8_full_walk_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_valid_o && !done_fault_o |-> done_level_o == LVL_W'(LEVELS - 1));

  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_valid_o |=> !done_valid_o && req_ready_o);
endmodule

bind page_walker page_walker_chk #(
  .ADDR_W(PPN_W + page_walker_pkg::OFS_W), .LVL_W($clog2(LEVELS)), .LEVELS(LEVELS)
) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_valid_i     (req_valid_i),
  .req_ready_o     (req_ready_o),
  .mem_req_valid_o (mem_req_valid_o),
  .mem_req_ready_i (mem_req_ready_i),
  .mem_req_addr_o  (mem_req_addr_o),
  .mem_rsp_valid_i (mem_rsp_valid_i),
  .done_valid_o    (done_valid_o),
  .done_fault_o    (done_fault_o),
  .done_level_o    (done_level_o)
);

// File: tb/page_walker_test.sv
module page_walker_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [35:0] req_vpn_i = '0;
  logic [39:0] root_base_i = '0;
  logic        mem_req_valid_o;
  logic        mem_req_ready_i = 1'b0;
  logic [51:0] mem_req_addr_o;
  logic        mem_rsp_valid_i = 1'b0;
  logic [63:0] mem_rsp_data_i = '0;
  logic        done_valid_o;
  logic        done_fault_o;
  logic [1:0]  done_level_o;
  logic [39:0] done_ppn_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk_i = ~clk_i;

  page_walker uut (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: next base derived arithmetically from the entry address
  function automatic logic [39:0] next_base(input logic [51:0] a);
    return a[39:0] ^ 40'hA5_0F3C_9617 ^ {a[51:40], 28'h0};
  endfunction

  task automatic do_walk(input logic [35:0] vpn, input logic [39:0] root, input int flvl, input int lat);
    logic [39:0] base = root;
    logic [51:0] ea;
    int nreq = (flvl < 4) ? flvl + 1 : 4;
    @(negedge clk_i);
    chk(req_ready_o === 1'b1, "R2 idle ready", req_ready_o, 1);
    req_valid_i = 1'b1; req_vpn_i = vpn; root_base_i = root;
    @(negedge clk_i);
    // stray request during the walk must be ignored (R2)
    req_vpn_i = ~vpn; root_base_i = ~root;
    chk(req_ready_o === 1'b0, "R2 busy", req_ready_o, 0);
    for (int l = 0; l < nreq; l++) begin
      ea = {base, 12'h000} + 52'(vpn[(3-l)*9 +: 9]) * 52'd8;
      chk(mem_req_valid_o === 1'b1, "R3/R4 req valid", mem_req_valid_o, 1);
      chk(mem_req_addr_o === ea, (l == 0) ? "R3 root addr" : "R4 level addr", mem_req_addr_o, ea);
      for (int d = 0; d < lat; d++) begin
        @(negedge clk_i);
        chk(mem_req_valid_o === 1'b1 && mem_req_addr_o === ea, "R5 hold", mem_req_addr_o, ea);
      end
      mem_req_ready_i = 1'b1;
      @(negedge clk_i);
      mem_req_ready_i = 1'b0;
      chk(mem_req_valid_o === 1'b0, "R6 no read while waiting", mem_req_valid_o, 0);
      for (int d = 0; d < lat; d++) begin
        @(negedge clk_i);
        chk(mem_req_valid_o === 1'b0, "R6 wait", mem_req_valid_o, 0);
      end
      base = next_base(ea);
      mem_rsp_data_i = {12'hFFF, base, 11'h2AA, (l != flvl)};
      mem_rsp_valid_i = 1'b1;
      @(negedge clk_i);
      mem_rsp_valid_i = 1'b0;
    end
    req_valid_i = 1'b0;
    chk(done_valid_o === 1'b1, "R9 done pulse", done_valid_o, 1);
    chk(mem_req_valid_o === 1'b0, "R7 no read after end", mem_req_valid_o, 0);
    if (flvl < 4) begin
      chk(done_fault_o === 1'b1, "R7 fault", done_fault_o, 1);
      chk(done_level_o === 2'(flvl), "R7 level", done_level_o, flvl);
      chk(done_ppn_o === '0, "R7 ppn zero", done_ppn_o, 0);
    end else begin
      chk(done_fault_o === 1'b0, "R8 no fault", done_fault_o, 0);
      chk(done_level_o === 2'd3, "R8 level", done_level_o, 3);
      chk(done_ppn_o === base, "R8 ppn", done_ppn_o, base);
    end
    @(negedge clk_i);
    chk(done_valid_o === 1'b0 && req_ready_o === 1'b1, "R9 back to idle",
        {done_valid_o, req_ready_o}, 2'b01);
  endtask

  initial begin
    logic [35:0] vpns [4];
    logic [39:0] roots [4];
    vpns[0] = 36'h0_0000_0000; vpns[1] = 36'hF_FFFF_FFFF;
    vpns[2] = 36'h1_FF00_7E03; vpns[3] = 36'hA_5C3E_1B9D;
    roots[0] = 40'h00_0000_0001; roots[1] = 40'hFF_FFFF_FFFF;
    roots[2] = 40'h12_3456_789A; roots[3] = 40'h80_0000_0000;
    repeat (3) @(negedge clk_i);
    chk(req_ready_o === 1'b1 && mem_req_valid_o === 1'b0 && done_valid_o === 1'b0,
        "R1 reset state", {req_ready_o, mem_req_valid_o, done_valid_o}, 3'b100);
    rst_ni = 1'b1;
    for (int v = 0; v < 4; v++)
      for (int f = 0; f <= 4; f++)
        for (int t = 0; t < 3; t++)
          do_walk(vpns[v], roots[(v + t) % 4], f, t);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule